// File: doc/BRIEF.md
# Byte-Length Command Splitter

This block takes one transfer request, a byte count of up to 24 bits and a command-word template, and breaks it into the sequence of queue entries a serial flash engine needs to move exactly that many bytes. Each entry holds an 8-bit count field in bits [7:0] and a scale flag in bit 9. With the flag clear, the count field is a plain byte count of 1 to 255. With the flag set, the field is an exponent `p` and the entry moves 2^p bytes.

While more than 255 bytes remain, the block takes the lowest set bit of the remaining length at position 8 or above. It emits a scaled entry for that bit and clears it from the remainder. The search starts again from bit 8 on every step, so the scaled entries come out in ascending order of exponent. What is left is then sent as one unscaled entry. For receive transfers that land in word-aligned memory, an alignment mode rounds that last count up to a multiple of four bytes.

Entries leave on a valid/ready stream and are held until they are accepted. A one-cycle done pulse closes each request. Executing the entries belongs to the downstream engine.

Top module: `cs_len_splitter`

## Requirements
- R1: After a synchronous reset, `cmd_valid_o` and `done_o` are low.
- R2: When the remaining length is 1 to 255 and alignment is off, the block emits one entry with bit 9 clear and bits [7:0] equal to the remaining length. That entry is the last one.
- R3: While the remaining length exceeds 255, each entry has bit 9 set and bits [7:0] equal to the position of the lowest set bit at or above bit 8. That bit is removed from the remainder, so exponents appear in ascending order.
- R4: When clearing a chunk bit leaves a remainder of zero, no unscaled entry follows (a length of 256 gives exactly one entry, exponent 8).
- R5: Every entry equals the template captured at start, except for bits [7:0] and bit 9.
- R6: With alignment on, a final remainder of 1 to 252 is emitted with bits [7:0] rounded up to the next multiple of 4.
- R7: With alignment on, a final remainder of 253 to 255 is emitted as one scaled entry with exponent 8, because the rounded count no longer fits 8 bits.
- R8: A start with length zero emits no entry, and `done_o` is high in the cycle after the start.
- R9: An entry is held stable on `cmd_o` while `cmd_valid_o` is high and `cmd_ready_i` is low. The next entry appears in the cycle after acceptance.
- R10: `done_o` is high for exactly one cycle, the cycle after the last entry is accepted, and never while an entry is valid.
- R11: A start pulse while an entry is pending is ignored. It changes neither the stream nor the number of entries.
- R12: The largest length, 2^24-1, yields scaled entries for exponents 8 through 23 followed by one entry of 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, sampled when no entry is pending |
| len_i | input | 24 | Transfer length in bytes |
| tmpl_i | input | 32 | Command template (select, direction and lane fields kept) |
| align_i | input | 1 | Round the final count up to a multiple of four |
| cmd_valid_o | output | 1 | Entry on `cmd_o` is valid |
| cmd_ready_i | input | 1 | Downstream accepts the entry |
| cmd_o | output | 32 | Queue entry |
| done_o | output | 1 | One-cycle pulse after the last entry of a request |

## Verification
The assertions check on every cycle that a stalled entry stays stable and that every entry keeps the template fields. They also check that unscaled counts are never zero and are word multiples in alignment mode, that exponents stay inside the length width, and that done never overlaps a valid entry. Other properties need whole requests and can only be shown by the bench scenarios. These are the ascending order of exponents, the absence of a trailing entry after an exact power-of-two chunk, the overflow of a rounded count into an exponent-8 entry, the zero-length done, and the fact that a start issued mid-request is ignored. The bench follows each of them with a queue-based model under fixed and random back-pressure.

// File: rtl/cs_split_pkg.sv
package cs_split_pkg;
  localparam int SPL_LEN_W    = 24;
  localparam int SPL_CMD_W    = 32;
  localparam int SPL_IMM_W    = 8;
  localparam int SPL_EXP_POS  = 9;
  localparam int SPL_ALIGN_LG = 2;
endpackage

// File: rtl/cs_lowbit_find.sv
module cs_lowbit_find #(
  parameter int W  = 24,
  parameter int LO = 8,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  logic [W:LO]   seen;
  logic [W-1:LO] hit;

  assign seen[LO] = 1'b0;
  for (genvar g = LO; g < W; g++) begin : g_scan
    assign hit[g]    = vec[g] & ~seen[g];
    assign seen[g+1] = seen[g] | vec[g];
  end
  assign found = seen[W];

  always_comb begin
    pos = '0;
    for (int i = LO; i < W; i++) begin
      if (hit[i]) pos = pos | PW'(i);
    end
  end
endmodule

// File: rtl/cs_entry_build.sv
module cs_entry_build #(
  parameter int LEN_W    = 24,
  parameter int CMD_W    = 32,
  parameter int IMM_W    = 8,
  parameter int EXP_POS  = 9,
  parameter int ALIGN_LG = 2,
  localparam int PW = $clog2(LEN_W)
) (
  input  logic [LEN_W-1:0] rem,
  input  logic [CMD_W-1:0] tmpl,
  input  logic             align,
  output logic [CMD_W-1:0] word,
  output logic [LEN_W-1:0] rest,
  output logic             last
);
  localparam logic [IMM_W:0] RND_ADD = (IMM_W+1)'((1 << ALIGN_LG) - 1);
  localparam logic [IMM_W:0] RND_MSK = ~RND_ADD;

  logic [PW-1:0] bit_pos;
  logic          big;
  logic [IMM_W:0] rnd;

  cs_lowbit_find #(.W(LEN_W), .LO(IMM_W)) u_find (
    .vec  (rem),
    .pos  (bit_pos),
    .found(big)
  );

  assign rnd = ({1'b0, rem[IMM_W-1:0]} + RND_ADD) & RND_MSK;

  always_comb begin
    word = tmpl;
    rest = '0;
    last = 1'b1;
    if (big) begin
      word[IMM_W-1:0] = IMM_W'(bit_pos);
      word[EXP_POS]   = 1'b1;
      rest            = rem & ~(LEN_W'(1) << bit_pos);
      last            = (rest == '0);
    end else if (align && rnd[IMM_W]) begin
      word[IMM_W-1:0] = IMM_W'(IMM_W);
      word[EXP_POS]   = 1'b1;
    end else begin
      word[IMM_W-1:0] = align ? rnd[IMM_W-1:0] : rem[IMM_W-1:0];
      word[EXP_POS]   = 1'b0;
    end
  end
endmodule

// File: rtl/cs_len_splitter.sv
module cs_len_splitter
  import cs_split_pkg::*;
#(
  parameter int LEN_W    = SPL_LEN_W,
  parameter int CMD_W    = SPL_CMD_W,
  parameter int IMM_W    = SPL_IMM_W,
  parameter int EXP_POS  = SPL_EXP_POS,
  parameter int ALIGN_LG = SPL_ALIGN_LG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CMD_W-1:0] tmpl_i,
  input  logic             align_i,
  output logic             cmd_valid_o,
  input  logic             cmd_ready_i,
  output logic [CMD_W-1:0] cmd_o,
  output logic             done_o
);
  logic             valid_q, last_q, align_q, done_q;
  logic [CMD_W-1:0] cmd_q, tmpl_q;
  logic [LEN_W-1:0] rest_q;

  logic             load, accept;
  logic [LEN_W-1:0] src_rem, enc_rest;
  logic [CMD_W-1:0] src_tmpl, enc_word;
  logic             src_align, enc_last;

  assign load   = start_i & ~valid_q;
  assign accept = valid_q & cmd_ready_i;

  assign src_rem   = load ? len_i   : rest_q;
  assign src_tmpl  = load ? tmpl_i  : tmpl_q;
  assign src_align = load ? align_i : align_q;

  cs_entry_build #(
    .LEN_W(LEN_W), .CMD_W(CMD_W), .IMM_W(IMM_W),
    .EXP_POS(EXP_POS), .ALIGN_LG(ALIGN_LG)
  ) u_build (
    .rem  (src_rem),
    .tmpl (src_tmpl),
    .align(src_align),
    .word (enc_word),
    .rest (enc_rest),
    .last (enc_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
      align_q <= 1'b0;
      cmd_q   <= '0;
      tmpl_q  <= '0;
      rest_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        tmpl_q  <= tmpl_i;
        align_q <= align_i;
        if (len_i == '0) begin
          done_q <= 1'b1;
        end else begin
          valid_q <= 1'b1;
          cmd_q   <= enc_word;
          last_q  <= enc_last;
          rest_q  <= enc_rest;
        end
      end else if (accept) begin
        if (last_q) begin
          valid_q <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          cmd_q  <= enc_word;
          last_q <= enc_last;
          rest_q <= enc_rest;
        end
      end
    end
  end

  assign cmd_valid_o = valid_q;
  assign cmd_o       = cmd_q;
  assign done_o      = done_q;
endmodule

// File: rtl/cs_len_splitter_chk.sv
module cs_len_splitter_chk #(
  parameter int LEN_W    = 24,
  parameter int CMD_W    = 32,
  parameter int IMM_W    = 8,
  parameter int EXP_POS  = 9,
  parameter int ALIGN_LG = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid_o,
  input logic             cmd_ready_i,
  input logic [CMD_W-1:0] cmd_o,
  input logic             done_o,
  input logic             align_q,
  input logic [CMD_W-1:0] tmpl_q
);
  localparam logic [CMD_W-1:0] KEEP =
    ~((CMD_W'(1) << EXP_POS) | CMD_W'((1 << IMM_W) - 1));
  localparam logic [IMM_W-1:0] AMSK = IMM_W'((1 << ALIGN_LG) - 1);

  logic [IMM_W-1:0] imm;
  assign imm = cmd_o[IMM_W-1:0];

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_o));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !cmd_valid_o);

  // R2
  imm_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && !cmd_o[EXP_POS] |-> imm != '0);

  // R3
  exp_range_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && cmd_o[EXP_POS] |-> (imm >= IMM_W) && (imm < LEN_W));

  // R6
  align_mult_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o && align_q && !cmd_o[EXP_POS] |-> (imm & AMSK) == '0);

  // R5
  tmpl_keep_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> (cmd_o & KEEP) == (tmpl_q & KEEP));
endmodule

bind cs_len_splitter cs_len_splitter_chk #(
  .LEN_W(LEN_W), .CMD_W(CMD_W), .IMM_W(IMM_W),
  .EXP_POS(EXP_POS), .ALIGN_LG(ALIGN_LG)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid_o(cmd_valid_o),
  .cmd_ready_i(cmd_ready_i),
  .cmd_o      (cmd_o),
  .done_o     (done_o),
  .align_q    (align_q),
  .tmpl_q     (tmpl_q)
);

// File: tb/cs_len_splitter_bench.sv
`timescale 1ns/1ps
module cs_len_splitter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [23:0] len_i = '0;
  logic [31:0] tmpl_i = '0;
  logic        align_i = 1'b0;
  logic        cmd_ready_i = 1'b0;
  logic        cmd_valid_o, done_o;
  logic [31:0] cmd_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit rdy_rand = 1'b0;
  bit rdy_hold = 1'b1;
  int acc_cnt = 0;

  logic [31:0] mq[$];
  bit m_busy = 1'b0;
  bit m_done = 1'b0;

  always #2.5 clk = ~clk;

  cs_len_splitter u_cs_len_splitter (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
    .tmpl_i(tmpl_i), .align_i(align_i), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_o(cmd_o), .done_o(done_o)
  );

  function automatic logic [31:0] mk(logic [31:0] t, int v, bit e);
    logic [31:0] w;
    w = t;
    w[7:0] = v[7:0];
    w[9] = e;
    return w;
  endfunction

  task automatic build(input int len, input logic [31:0] t, input bit al,
                       ref logic [31:0] q[$]);
    int r;
    r = len;
    q.delete();
    while (r > 0) begin
      if (r > 255) begin
        int p;
        p = 8;
        while (((r >> p) & 1) == 0) p++;
        q.push_back(mk(t, p, 1'b1));
        r = r - (1 << p);
      end else begin
        int c;
        c = al ? ((r + 3) / 4) * 4 : r;
        if (c > 255) q.push_back(mk(t, 8, 1'b1));
        else q.push_back(mk(t, c, 1'b0));
        r = 0;
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_busy = 1'b0;
      m_done = 1'b0;
    end else begin
      bit dn;
      dn = 1'b0;
      if (cmd_valid_o && cmd_ready_i) acc_cnt++;
      if (m_busy) begin
        if (cmd_ready_i) begin
          void'(mq.pop_front());
          if (mq.size() == 0) begin
            m_busy = 1'b0;
            dn = 1'b1;
          end
        end
      end else if (start_i) begin
        build(int'(len_i), tmpl_i, align_i, mq);
        if (mq.size() == 0) dn = 1'b1;
        else m_busy = 1'b1;
      end
      m_done = dn;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rdy_rand) cmd_ready_i = 1'($urandom % 2);
    else cmd_ready_i = rdy_hold;
    if (!rst) begin
      chk(cmd_valid_o == m_busy, "valid", 32'(cmd_valid_o), 32'(m_busy));
      chk(done_o == m_done, "done", 32'(done_o), 32'(m_done));
      if (m_busy && cmd_valid_o)
        chk(cmd_o == mq[0], "entry", cmd_o, mq[0]);
    end
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run(input int len, input logic [31:0] t, input bit al);
    @(negedge clk);
    start_i = 1'b1; len_i = 24'(len); tmpl_i = t; align_i = al;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (done_o) break;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk(!cmd_valid_o && !done_o, "reset", {cmd_valid_o, done_o}, 0);

    cur_req = "R2"; run(100, 32'h0001_5000, 1'b0);
    run(255, 32'h0002_5400, 1'b0);
    cur_req = "R3"; run(24'h001234, 32'h0001_5000, 1'b0);
    run(24'h0A0301, 32'h0002_5000, 1'b0);
    cur_req = "R4"; run(256, 32'h0001_5000, 1'b0);
    run(24'h010300, 32'h0001_5000, 1'b0);
    cur_req = "R5"; run(24'h000345, 32'hFFFF_FD00, 1'b0);
    run(24'h000345, 32'hA5A5_A5A5, 1'b1);
    cur_req = "R6"; run(7, 32'h0002_5000, 1'b1);
    run(24'h000101, 32'h0002_5000, 1'b1);
    run(252, 32'h0002_5000, 1'b1);
    cur_req = "R7"; run(254, 32'h0002_5000, 1'b1);
    run(24'h000FFD, 32'h0002_5000, 1'b1);
    cur_req = "R8"; run(0, 32'h0001_5000, 1'b0);
    run(0, 32'h0001_5000, 1'b1);
    cur_req = "R12"; run(24'hFFFFFF, 32'h0001_5000, 1'b0);

    cur_req = "R9";
    rdy_rand = 1'b1;
    run(24'h00F7A3, 32'h0001_5000, 1'b0);
    run(24'h7FFFFF, 32'h0002_5000, 1'b1);
    for (int n = 0; n < 40; n++)
      run(int'($urandom % 24'hFFFFFF), $urandom, 1'($urandom % 2));
    rdy_rand = 1'b0;

    cur_req = "R11";
    begin
      logic [31:0] eq[$];
      build(24'h001301, 32'h0001_5000, 1'b0, eq);
      rdy_hold = 1'b0;
      acc_cnt = 0;
      @(negedge clk);
      start_i = 1'b1; len_i = 24'h001301; tmpl_i = 32'h0001_5000; align_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      start_i = 1'b1; len_i = 24'h000005; tmpl_i = 32'h0003_6000;
      @(negedge clk);
      start_i = 1'b0;
      rdy_hold = 1'b1;
      for (int k = 0; k < 200; k++) begin
        if (done_o) break;
        @(negedge clk);
      end
      repeat (3) @(negedge clk);
      chk(acc_cnt == eq.size(), "entry count", 32'(acc_cnt), 32'(eq.size()));
    end

    cur_req = "R10";
    run(24'h000300, 32'h0001_5000, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule